// File: doc/BRIEF.md
# SDRAM Command Decoder and Bank Tracker

This block sits on the device side of a four-bank single-data-rate SDRAM front end. On each rising clock edge it samples the chip-select, row strobe, column strobe and write-enable lines, the clock-enable line, the two bank-select bits and the twelve address bits. From the strobes it decodes bank activate, precharge of one bank or of all banks, read, write and mode register set. Any other strobe pattern, and any cycle with chip select high, is a no-operation.

For every bank the block keeps an idle or active state and the row that was last opened. For each legal column access it reports the bank, the column, the direction and whether auto precharge was asked for. A column access with auto precharge closes its bank one cycle after the command. Reads or writes to closed banks, activates to open banks and mode register writes while any bank is open are reported as illegal, and none of them changes any state. Driving clock-enable low suspends every state update from the following cycle onward for as long as it stays low.

Top module: `sdram_cmd_tracker`

## Requirements
- R1: When cs_n is sampled high, the cycle is a no-operation whatever the other strobes are. No bank state or mode changes, and illegal, mrs_err and col_valid read 0 after that edge.
- R2: Strobes (cs_n,ras_n,cas_n,we_n)=0011 activate the bank selected by ba, where ba 0..3 is bank A..D and bit i of bank_active is bank i. The bank becomes active and open_row[12*ba +: 12] takes addr[11:0].
- R3: Strobes 0010 precharge. With addr[10]=1 all banks go idle. Otherwise only bank ba goes idle. Precharging an idle bank is legal and has no effect.
- R4: Strobes 0101 (read) and 0100 (write) to an active bank are column accesses. After the edge, col_valid=1 for one cycle with col_write=0 for read and 1 for write, col_bank=ba and col_addr=addr[8:0]. Bank states are unchanged at that edge.
- R5: A column access with addr[10]=1 sets auto_pre with col_valid. Its bank stays active after the command edge and goes idle at the next enabled edge. A command at that next edge sees the bank as idle.
- R6: A read or write to an idle bank, or an activate to an active bank, sets illegal for one cycle. It changes no bank state or row and produces no column report.
- R7: Strobes 0000 are mode register set. When all banks are idle, mode_reg takes addr[11:0]. Otherwise mrs_err is set for one cycle and mode_reg is unchanged.
- R8: When cke is sampled low at an edge, that edge still acts on its command. Every later edge is ignored up to and including the first edge at which cke is sampled high again. While suspended, all outputs hold their values.
- R9: Reset (rst_n low) leaves all banks idle, mode_reg at 0 and all flags at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge samples all inputs |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| cke | input | 1 | Clock enable |
| ba | input | 2 | Bank select |
| addr | input | 12 | Row, column, qualifier or opcode |
| bank_active | output | 4 | Active flag per bank |
| open_row | output | 48 | Open row per bank, 12 bits each, bank 0 lowest |
| mode_reg | output | 12 | Last accepted mode opcode |
| col_valid | output | 1 | Legal column access at last enabled edge |
| col_write | output | 1 | Column access was a write |
| col_bank | output | 2 | Bank of the column access |
| col_addr | output | 9 | Column of the column access |
| auto_pre | output | 1 | Column access requested auto precharge |
| illegal | output | 1 | Illegal bank access at last enabled edge |
| mrs_err | output | 1 | Mode register set refused, a bank was open |

## Verification
The checker enforces several rules at every edge. A deselected or illegal cycle never moves bank state. A suspended cycle freezes all outputs. An accepted activate always leaves its bank open. An auto-precharge report is always followed by that bank closing. A refused mode write never coincides with a column report or an illegal flag. The exact row and column values, the all-bank versus single-bank precharge choice, the decode of each strobe pattern and the exact edge at which a suspension ends depend on concrete sequences. Only the bench scenarios show those.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;
  typedef enum logic [2:0] {
    C_NOP = 3'd0,
    C_ACT = 3'd1,
    C_PRE = 3'd2,
    C_RD  = 3'd3,
    C_WR  = 3'd4,
    C_MRS = 3'd5
  } cmd_e;

  // strobe pattern to command; unsupported patterns collapse to no-op
  function automatic cmd_e decode_cmd(input logic cs_n, input logic ras_n,
                                      input logic cas_n, input logic we_n);
    cmd_e c;
    c = C_NOP;
    if (!cs_n) begin
      case ({ras_n, cas_n, we_n})
        3'b011:  c = C_ACT;
        3'b010:  c = C_PRE;
        3'b101:  c = C_RD;
        3'b100:  c = C_WR;
        3'b000:  c = C_MRS;
        default: c = C_NOP;
      endcase
    end
    return c;
  endfunction

  function automatic logic [3:0] bank_onehot(input logic [1:0] b);
    return 4'b0001 << b;
  endfunction
endpackage

// File: rtl/sdcmd_bank.sv
module sdcmd_bank #(
  parameter int ROW_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             do_open,
  input  logic             do_close,
  input  logic [ROW_W-1:0] row_in,
  output logic             active,
  output logic [ROW_W-1:0] row
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      row    <= '0;
    end else if (en) begin
      if (do_open) begin
        active <= 1'b1;
        row    <= row_in;
      end else if (do_close) begin
        active <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sdcmd_colport.sv
module sdcmd_colport #(
  parameter int COL_W = 9,
  parameter int BA_W  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             hit,
  input  logic             wr,
  input  logic             ap,
  input  logic             bad,
  input  logic             merr,
  input  logic [BA_W-1:0]  bank_in,
  input  logic [COL_W-1:0] col_in,
  output logic             col_valid,
  output logic             col_write,
  output logic             auto_pre,
  output logic             illegal,
  output logic             mrs_err,
  output logic [BA_W-1:0]  col_bank,
  output logic [COL_W-1:0] col_addr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_valid <= 1'b0;
      col_write <= 1'b0;
      auto_pre  <= 1'b0;
      illegal   <= 1'b0;
      mrs_err   <= 1'b0;
      col_bank  <= '0;
      col_addr  <= '0;
    end else if (en) begin
      col_valid <= hit;
      col_write <= hit & wr;
      auto_pre  <= hit & ap;
      illegal   <= bad;
      mrs_err   <= merr;
      if (hit) begin
        col_bank <= bank_in;
        col_addr <= col_in;
      end
    end
  end
endmodule

// File: rtl/sdcmd_modereg.sv
module sdcmd_modereg #(
  parameter int OP_W = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic            load,
  input  logic [OP_W-1:0] op_in,
  output logic [OP_W-1:0] mode_reg
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            mode_reg <= '0;
    else if (en && load)   mode_reg <= op_in;
  end
endmodule

// File: rtl/sdram_cmd_tracker.sv
module sdram_cmd_tracker
  import sdcmd_pkg::*;
#(
  parameter int ROW_W  = 12,
  parameter int COL_W  = 9,
  parameter int BA_W   = 2,
  parameter int AP_BIT = 10
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cs_n,
  input  logic                          ras_n,
  input  logic                          cas_n,
  input  logic                          we_n,
  input  logic                          cke,
  input  logic [BA_W-1:0]               ba,
  input  logic [ROW_W-1:0]              addr,
  output logic [(1<<BA_W)-1:0]          bank_active,
  output logic [(1<<BA_W)*ROW_W-1:0]    open_row,
  output logic [ROW_W-1:0]              mode_reg,
  output logic                          col_valid,
  output logic                          col_write,
  output logic [BA_W-1:0]               col_bank,
  output logic [COL_W-1:0]              col_addr,
  output logic                          auto_pre,
  output logic                          illegal,
  output logic                          mrs_err
);
  localparam int NBANK = 1 << BA_W;

  // named internal events for the checker
  cmd_e             cmd;
  logic             step_en;
  logic             cke_q;
  logic             ap_pend;
  logic [BA_W-1:0]  ap_bank;
  logic [NBANK-1:0] ap_mask;
  logic [NBANK-1:0] eff_active;
  logic             sel_hit;
  logic             ev_act, ev_pre, ev_col, ev_col_ok, ev_bad;
  logic             ev_mrs_ok, ev_mrs_bad, ev_ap;

  assign cmd = decode_cmd(cs_n, ras_n, cas_n, we_n);

  // suspension starts one edge after cke is sampled low
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cke_q <= 1'b1;
    else        cke_q <= cke;
  end
  assign step_en = cke_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ap_pend <= 1'b0;
      ap_bank <= '0;
    end else if (step_en) begin
      ap_pend <= ev_ap;
      if (ev_ap) ap_bank <= ba;
    end
  end

  always_comb begin
    ap_mask = '0;
    if (ap_pend) ap_mask[ap_bank] = 1'b1;
  end

  assign eff_active = bank_active & ~ap_mask;
  assign sel_hit    = eff_active[ba];
  assign ev_act     = (cmd == C_ACT);
  assign ev_pre     = (cmd == C_PRE);
  assign ev_col     = (cmd == C_RD) || (cmd == C_WR);
  assign ev_col_ok  = ev_col && sel_hit;
  assign ev_ap      = ev_col_ok && addr[AP_BIT];
  assign ev_bad     = (ev_act && sel_hit) || (ev_col && !sel_hit);
  assign ev_mrs_ok  = (cmd == C_MRS) && (eff_active == '0);
  assign ev_mrs_bad = (cmd == C_MRS) && (eff_active != '0);

  genvar gi;
  generate
    for (gi = 0; gi < NBANK; gi++) begin : g_bank
      logic open_i, close_i;
      assign open_i  = ev_act && !sel_hit && (ba == BA_W'(gi));
      assign close_i = ap_mask[gi] ||
                       (ev_pre && (addr[AP_BIT] || (ba == BA_W'(gi))));
      sdcmd_bank #(.ROW_W(ROW_W)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (step_en),
        .do_open  (open_i),
        .do_close (close_i),
        .row_in   (addr),
        .active   (bank_active[gi]),
        .row      (open_row[gi*ROW_W +: ROW_W])
      );
    end
  endgenerate

  sdcmd_colport #(.COL_W(COL_W), .BA_W(BA_W)) u_col (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (step_en),
    .hit       (ev_col_ok),
    .wr        (cmd == C_WR),
    .ap        (addr[AP_BIT]),
    .bad       (ev_bad),
    .merr      (ev_mrs_bad),
    .bank_in   (ba),
    .col_in    (addr[COL_W-1:0]),
    .col_valid (col_valid),
    .col_write (col_write),
    .auto_pre  (auto_pre),
    .illegal   (illegal),
    .mrs_err   (mrs_err),
    .col_bank  (col_bank),
    .col_addr  (col_addr)
  );

  sdcmd_modereg #(.OP_W(ROW_W)) u_mode (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (step_en),
    .load     (ev_mrs_ok),
    .op_in    (addr),
    .mode_reg (mode_reg)
  );
endmodule

// File: rtl/sdram_cmd_tracker_chk.sv
module sdram_cmd_tracker_chk #(
  parameter int BA_W  = 2,
  parameter int ROW_W = 12
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 cs_n,
  input logic                 step_en,
  input logic                 ev_act,
  input logic                 ev_bad,
  input logic                 ap_pend,
  input logic [(1<<BA_W)-1:0] eff_active,
  input logic [BA_W-1:0]      ba,
  input logic [(1<<BA_W)-1:0] bank_active,
  input logic [ROW_W-1:0]     mode_reg,
  input logic                 col_valid,
  input logic [BA_W-1:0]      col_bank,
  input logic                 auto_pre,
  input logic                 illegal,
  input logic                 mrs_err
);
  a_r1_deselect_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && cs_n && !ap_pend) |=> ($stable(bank_active) && !illegal && !col_valid && !mrs_err));

  a_r6_illegal_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && ev_bad && !ap_pend) |=> ($stable(bank_active) && illegal && !col_valid));

  a_r2_activate_opens: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && ev_act && !eff_active[ba]) |=> bank_active[$past(ba)]);

  a_r5_autopre_closes: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && col_valid && auto_pre && !(ev_act && ba == col_bank)) |=> !bank_active[$past(col_bank)]);

  a_r8_suspend_freezes: assert property (@(posedge clk) disable iff (!rst_n)
    !step_en |=> ($stable(bank_active) && $stable(mode_reg) && $stable(col_valid) && $stable(illegal) && $stable(mrs_err)));

  a_r7_mrs_err_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    mrs_err |-> (!col_valid && !illegal));
endmodule

bind sdram_cmd_tracker sdram_cmd_tracker_chk #(.BA_W(BA_W), .ROW_W(ROW_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .step_en(step_en), .ev_act(ev_act),
  .ev_bad(ev_bad), .ap_pend(ap_pend), .eff_active(eff_active), .ba(ba),
  .bank_active(bank_active), .mode_reg(mode_reg), .col_valid(col_valid),
  .col_bank(col_bank), .auto_pre(auto_pre), .illegal(illegal), .mrs_err(mrs_err)
);

// File: tb/sdram_cmd_tracker_tb_top.sv
module sdram_cmd_tracker_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 21;

  // strobe patterns {cs_n,ras_n,cas_n,we_n}
  localparam logic [3:0] K_ACT = 4'b0011, K_PRE = 4'b0010, K_RD = 4'b0101,
                         K_WR = 4'b0100, K_MRS = 4'b0000, K_NOP = 4'b0111,
                         K_DES = 4'b1000;

  // [27:24] strobes [23] cke [22:21] ba [20:9] addr [8:5] exp bank_active
  // [4:0] exp {illegal,col_valid,col_write,auto_pre,mrs_err}
  localparam logic [27:0] VEC [NV] = '{
    {K_MRS, 1'b1, 2'd0, 12'h032, 4'b0000, 5'b00000}, // R7 accepted
    {K_ACT, 1'b1, 2'd0, 12'h123, 4'b0001, 5'b00000}, // R2
    {K_ACT, 1'b1, 2'd2, 12'h456, 4'b0101, 5'b00000}, // R2
    {K_ACT, 1'b1, 2'd0, 12'h777, 4'b0101, 5'b10000}, // R6 act active
    {K_RD,  1'b1, 2'd1, 12'h001, 4'b0101, 5'b10000}, // R6 read idle
    {K_RD,  1'b1, 2'd0, 12'h005, 4'b0101, 5'b01000}, // R4 read
    {K_WR,  1'b1, 2'd2, 12'h40A, 4'b0101, 5'b01110}, // R4 R5 write+ap
    {K_NOP, 1'b1, 2'd0, 12'h000, 4'b0001, 5'b00000}, // R5 closed
    {K_MRS, 1'b1, 2'd0, 12'h0FF, 4'b0001, 5'b00001}, // R7 refused
    {K_DES, 1'b1, 2'd1, 12'h000, 4'b0001, 5'b00000}, // R1 masked
    {K_ACT, 1'b1, 2'd3, 12'hABC, 4'b1001, 5'b00000}, // R2
    {K_PRE, 1'b1, 2'd0, 12'h000, 4'b1000, 5'b00000}, // R3 single
    {K_ACT, 1'b1, 2'd1, 12'h111, 4'b1010, 5'b00000}, // R2
    {K_PRE, 1'b1, 2'd0, 12'h400, 4'b0000, 5'b00000}, // R3 all
    {K_PRE, 1'b1, 2'd2, 12'h000, 4'b0000, 5'b00000}, // R3 idle bank
    {K_WR,  1'b1, 2'd3, 12'h000, 4'b0000, 5'b10000}, // R6 write idle
    {K_ACT, 1'b1, 2'd0, 12'h0F0, 4'b0001, 5'b00000}, // R2
    {K_RD,  1'b0, 2'd0, 12'h403, 4'b0001, 5'b01010}, // R8 edge still acts
    {K_ACT, 1'b0, 2'd1, 12'h222, 4'b0001, 5'b01010}, // R8 suspended
    {K_NOP, 1'b1, 2'd0, 12'h000, 4'b0001, 5'b01010}, // R8 still suspended
    {K_NOP, 1'b1, 2'd0, 12'h000, 4'b0000, 5'b00000}  // R8 R5 resumes
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, cke = 1'b1;
  logic [1:0]  ba = '0;
  logic [11:0] addr = '0;
  logic [3:0]  bank_active;
  logic [47:0] open_row;
  logic [11:0] mode_reg;
  logic        col_valid, col_write, auto_pre, illegal, mrs_err;
  logic [1:0]  col_bank;
  logic [8:0]  col_addr;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdram_cmd_tracker dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .cke(cke), .ba(ba), .addr(addr), .bank_active(bank_active),
    .open_row(open_row), .mode_reg(mode_reg), .col_valid(col_valid),
    .col_write(col_write), .col_bank(col_bank), .col_addr(col_addr),
    .auto_pre(auto_pre), .illegal(illegal), .mrs_err(mrs_err)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive at negedge, one edge samples it, look at the following negedge
  task automatic issue(input logic [3:0] k, input logic ck, input logic [1:0] b,
                       input logic [11:0] a);
    {cs_n, ras_n, cas_n, we_n} = k;
    cke = ck; ba = b; addr = a;
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [11:0] row_of(input logic [47:0] r, input int b);
    return r[b*12 +: 12];
  endfunction

  initial begin
    repeat (2) @(negedge clk);
    check("R9 reset bank_active", 32'(bank_active), 32'h0);
    check("R9 reset mode_reg", 32'(mode_reg), 32'h0);
    check("R9 reset flags", 32'({illegal, col_valid, mrs_err}), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [27:0] v;
      v = VEC[i];
      issue(v[27:24], v[23], v[22:21], v[20:9]);
      check($sformatf("vector %0d R1-state/R2/R3/R5/R6/R8 bank_active", i),
            32'(bank_active), 32'(v[8:5]));
      check($sformatf("vector %0d R4/R6/R7 flags", i),
            32'({illegal, col_valid, col_write, auto_pre, mrs_err}), 32'(v[4:0]));
      if (i == 2) begin
        check("R2 row bank0", 32'(row_of(open_row, 0)), 32'h123);
        check("R2 row bank2", 32'(row_of(open_row, 2)), 32'h456);
      end
      if (i == 3) check("R6 row unchanged", 32'(row_of(open_row, 0)), 32'h123);
      if (i == 5) check("R4 col addr/bank", 32'({col_bank, col_addr}), 32'({2'd0, 9'h005}));
      if (i == 6) check("R4 write col addr/bank", 32'({col_bank, col_addr}), 32'({2'd2, 9'h00A}));
      if (i == 0) check("R7 mode loaded", 32'(mode_reg), 32'h032);
      if (i == 8) check("R7 mode kept", 32'(mode_reg), 32'h032);
      if (i == 9) check("R1 mode unchanged by deselect", 32'(mode_reg), 32'h032);
      if (i == 18) check("R8 row of suspended activate", 32'(row_of(open_row, 1)), 32'h111);
    end
    check("R3 row kept after close", 32'(row_of(open_row, 3)), 32'hABC);
    check("R2 row bank0 final", 32'(row_of(open_row, 0)), 32'h0F0);

    // R5: reactivating the auto-precharged bank on the very next edge is legal
    issue(K_ACT, 1'b1, 2'd1, 12'h333);
    issue(K_RD,  1'b1, 2'd1, 12'h407);
    issue(K_ACT, 1'b1, 2'd1, 12'h344);
    check("R5 reopen after ap", 32'({bank_active, illegal}), 32'({4'b0010, 1'b0}));
    check("R5 reopen row", 32'(row_of(open_row, 1)), 32'h344);
    // R5: a read right after an auto-precharge command sees an idle bank
    issue(K_RD,  1'b1, 2'd1, 12'h400);
    issue(K_RD,  1'b1, 2'd1, 12'h001);
    check("R5 read after ap is illegal", 32'({bank_active, illegal, col_valid}),
          32'({4'b0000, 1'b1, 1'b0}));

    // R9: reset mid-run
    issue(K_ACT, 1'b1, 2'd3, 12'h055);
    rst_n = 1'b0;
    #1;
    check("R9 async reset", 32'({bank_active, mode_reg}), 32'h0);
    @(negedge clk);
    rst_n = 1'b1;

    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule